// File: doc/BRIEF.md
# SD/MMC Command Response Checker

This block listens on the command line of an SD/MMC card after a command has gone out. A one-cycle `start` pulse opens a response window. From then on the line is sampled only in cycles where the serial-clock enable `sck_en` is high. The block waits for the card's start bit and gives up after a bounded number of idle samples. It then shifts in either a 48-bit short token or a 136-bit long token.

For short tokens the block runs a serial CRC7 over the header and payload and compares it with the CRC field the card sent. It also checks the end bit. When enabled, it XORs the 32-bit card status field with a reference value, masks the result and flags any remaining difference. Long tokens are only captured and their end bit checked.

The outcome is reported through a timeout flag and a response-error flag, each gated by its own interrupt enable, plus a stop-DMA level on timeout and a one-cycle `done` pulse. The captured token and card status word stay on the outputs until the next window opens.

The controller is a four-state machine:
- **IDLE → HUNT** on `start`.
- In **HUNT**, a low sample (the start bit) moves to **SHIFT**.
- In **HUNT**, the 64th consecutive high sample returns to **IDLE** with a timeout.
- **SHIFT → EVAL** on the last bit of the token.
- **EVAL → IDLE** unconditionally, after the error verdict is registered.
- A `start` pulse outside IDLE is ignored.

Top module: `sdmmc_resp_checker`

## Requirements
- R1: After `start`, if 64 consecutive `sck_en` samples of `cmd_in` are all 1, `timeout_flag` is set and `resp_err_flag` stays 0. A start bit (0) seen on the 64th sample is still accepted as a response.
- R2: `stop_dma` is high while `timeout_flag` is set. Both are cleared by the next `start`.
- R3: `irq_timeout` equals `timeout_flag` AND `timeout_irq_en`.
- R4: For a short token, a CRC7 with polynomial x^7+x^3+1 and initial value 0 is run over the first 40 received bits, most significant first. Token bits are numbered 47 (start) down to 0 (end). A mismatch between this CRC and token bits 7:1 sets `resp_err_flag`.
- R5: An end bit (token bit 0) of 0 sets `resp_err_flag`, in both short and long mode.
- R6: With `check_status` high at `start`, `resp_err_flag` is set when ((token[39:8] XOR `status_ref`) AND `status_mask`) is nonzero. With `check_status` low, the status field has no effect.
- R7: `irq_error` equals `resp_err_flag` AND `error_irq_en`.
- R8: With `long_mode` high at `start`, 136 bits are captured and neither the CRC nor the status check is applied.
- R9: `card_status` shows token[39:8] of the last short response once `done` pulses. It reads 0 from the cycle after a new `start`.
- R10: `done` is a one-cycle pulse, given exactly once per response window, for success, error or timeout alike.
- R11: `cmd_in` is sampled only in cycles with `sck_en` high. Its value in other cycles has no effect.
- R12: `resp_token` holds the received bits right-aligned, with the last received bit at bit 0 and upper unused bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_en | input | 1 | Serial-clock sampling enable |
| start | input | 1 | Opens a response window (accepted in IDLE only) |
| long_mode | input | 1 | 1 selects the 136-bit token |
| check_status | input | 1 | Enables the masked card-status comparison |
| cmd_in | input | 1 | Command line from the card |
| status_ref | input | 32 | Reference value XORed with the status field |
| status_mask | input | 32 | Mask applied after the XOR |
| timeout_irq_en | input | 1 | Interrupt enable for the timeout flag |
| error_irq_en | input | 1 | Interrupt enable for the error flag |
| busy | output | 1 | High while the state machine is outside IDLE |
| done | output | 1 | One-cycle completion pulse |
| timeout_flag | output | 1 | No start bit within the window |
| resp_err_flag | output | 1 | CRC, end-bit or status mismatch |
| stop_dma | output | 1 | Halts DMA request activity on timeout |
| irq_timeout | output | 1 | Gated timeout interrupt |
| irq_error | output | 1 | Gated error interrupt |
| card_status | output | 32 | Captured card status word |
| resp_token | output | 136 | Captured token, right-aligned |

## Verification
Short tokens are sent in four kinds:
- a clean one, which separates a correct CRC7 from one computed with the wrong polynomial or over the wrong span;
- one with a single CRC bit flipped;
- one with a zero end bit;
- one with a status field that differs from the reference only in a bit that is then masked out, masked in, or checked with the comparison disabled, which tells apart XOR-then-mask from mask-only or always-on checking.

The window timing is probed with 63 idle samples followed by a token and with 64 idle samples, which pins the timeout bound to the exact sample. Throughout all tests, `cmd_in` is inverted in every cycle without `sck_en`, so any sampling outside the enable corrupts a result.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SHIFT,
        ST_EVAL
    } rsp_state_e;

    localparam int SHORT_TOKEN_BITS = 48;
    localparam int LONG_TOKEN_BITS  = 136;
    localparam int CRC7_BITS        = 7;
endpackage

// File: rtl/sdrc_crc7.sv
module sdrc_crc7 #(
    parameter int  WIDTH = 7,
    parameter logic [WIDTH-1:0] POLY = 7'h09
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             din,
    output logic [WIDTH-1:0] crc
);
    logic feedback;
    assign feedback = din ^ crc[WIDTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clear) begin
            crc <= '0;
        end else if (enable) begin
            crc <= {crc[WIDTH-2:0], 1'b0} ^ (feedback ? POLY : '0);
        end
    end
endmodule

// File: rtl/sdrc_timer.sv
module sdrc_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] count;

    assign expired = tick && (count == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick && !expired) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sdmmc_resp_checker.sv
module sdmmc_resp_checker
    import sdrc_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64,
    parameter int SHORT_LEN     = SHORT_TOKEN_BITS,
    parameter int LONG_LEN      = LONG_TOKEN_BITS,
    parameter int STATUS_W      = 32,
    parameter int STATUS_LSB    = 8,
    parameter int CRC_W         = CRC7_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck_en,
    input  logic                start,
    input  logic                long_mode,
    input  logic                check_status,
    input  logic                cmd_in,
    input  logic [STATUS_W-1:0] status_ref,
    input  logic [STATUS_W-1:0] status_mask,
    input  logic                timeout_irq_en,
    input  logic                error_irq_en,
    output logic                busy,
    output logic                done,
    output logic                timeout_flag,
    output logic                resp_err_flag,
    output logic                stop_dma,
    output logic                irq_timeout,
    output logic                irq_error,
    output logic [STATUS_W-1:0] card_status,
    output logic [LONG_LEN-1:0] resp_token
);
    localparam int CNT_W    = $clog2(LONG_LEN + 1);
    localparam int CRC_SPAN = SHORT_LEN - CRC_W - 1;

    rsp_state_e        state, nxt_state;
    logic [CNT_W-1:0]  bit_cnt;
    logic              mode_long_q, check_q;
    logic [CRC_W-1:0]  crc_calc;
    logic              crc_clear, crc_enable;
    logic              hunt_tick, hunt_expired;
    logic              start_seen, last_bit;
    logic              end_bad, crc_bad, status_bad, verdict_err;

    // Start bit found while hunting
    assign start_seen = (state == ST_HUNT) && sck_en && !cmd_in;
    assign last_bit   = mode_long_q ? (bit_cnt == CNT_W'(LONG_LEN - 1))
                                    : (bit_cnt == CNT_W'(SHORT_LEN - 1));

    assign crc_clear  = (state == ST_IDLE) && start;
    assign crc_enable = start_seen ||
                        ((state == ST_SHIFT) && sck_en && (bit_cnt < CNT_W'(CRC_SPAN)));
    assign hunt_tick  = (state == ST_HUNT) && sck_en && cmd_in;

    sdrc_crc7 #(.WIDTH(CRC_W), .POLY(CRC_W'(9))) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (crc_clear),
        .enable (crc_enable),
        .din    (cmd_in),
        .crc    (crc_calc)
    );

    sdrc_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clear),
        .tick    (hunt_tick),
        .expired (hunt_expired)
    );

    // Verdict terms, evaluated in ST_EVAL
    assign end_bad     = !resp_token[0];
    assign crc_bad     = (crc_calc != resp_token[CRC_W:1]);
    assign status_bad  = check_q &&
                         (|((resp_token[STATUS_LSB +: STATUS_W] ^ status_ref) & status_mask));
    assign verdict_err = end_bad || (!mode_long_q && (crc_bad || status_bad));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Transitions
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:  if (start) nxt_state = ST_HUNT;
            ST_HUNT:  if (start_seen)        nxt_state = ST_SHIFT;
                      else if (hunt_expired) nxt_state = ST_IDLE;
            ST_SHIFT: if (sck_en && last_bit) nxt_state = ST_EVAL;
            ST_EVAL:  nxt_state = ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done          <= 1'b0;
            timeout_flag  <= 1'b0;
            resp_err_flag <= 1'b0;
            card_status   <= '0;
            resp_token    <= '0;
            bit_cnt       <= '0;
            mode_long_q   <= 1'b0;
            check_q       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    timeout_flag  <= 1'b0;
                    resp_err_flag <= 1'b0;
                    card_status   <= '0;
                    resp_token    <= '0;
                    bit_cnt       <= '0;
                    mode_long_q   <= long_mode;
                    check_q       <= check_status;
                end
                ST_HUNT: if (start_seen) begin
                    resp_token <= {resp_token[LONG_LEN-2:0], 1'b0};
                    bit_cnt    <= CNT_W'(1);
                end else if (hunt_expired) begin
                    timeout_flag <= 1'b1;
                    done         <= 1'b1;
                end
                ST_SHIFT: if (sck_en) begin
                    resp_token <= {resp_token[LONG_LEN-2:0], cmd_in};
                    bit_cnt    <= bit_cnt + 1'b1;
                end
                ST_EVAL: begin
                    resp_err_flag <= verdict_err;
                    done          <= 1'b1;
                    if (!mode_long_q)
                        card_status <= resp_token[STATUS_LSB +: STATUS_W];
                end
                default: ;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign stop_dma    = timeout_flag;
    assign irq_timeout = timeout_flag & timeout_irq_en;
    assign irq_error   = resp_err_flag & error_irq_en;
endmodule

// File: rtl/sdrc_checker.sv
module sdrc_checker #(
    parameter int STATUS_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic                timeout_flag,
    input logic                resp_err_flag,
    input logic                stop_dma,
    input logic [STATUS_W-1:0] card_status
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R10
    AST_TIMEOUT_NOT_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout_flag && resp_err_flag)); // R1
    AST_STOP_DMA_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_dma) |-> done); // R2
    AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(resp_err_flag)); // R4
    AST_STATUS_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(card_status)); // R9
endmodule

bind sdmmc_resp_checker sdrc_checker #(.STATUS_W(STATUS_W)) u_sdrc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .timeout_flag  (timeout_flag),
    .resp_err_flag (resp_err_flag),
    .stop_dma      (stop_dma),
    .card_status   (card_status)
);

// File: tb/tb_sdmmc_resp_checker.sv
module tb_sdmmc_resp_checker;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck_en = 1'b0;
    logic         start = 1'b0;
    logic         long_mode = 1'b0;
    logic         check_status = 1'b0;
    logic         cmd_in = 1'b1;
    logic [31:0]  status_ref = '0;
    logic [31:0]  status_mask = '0;
    logic         timeout_irq_en = 1'b0;
    logic         error_irq_en = 1'b0;
    logic         busy, done, timeout_flag, resp_err_flag, stop_dma;
    logic         irq_timeout, irq_error;
    logic [31:0]  card_status;
    logic [135:0] resp_token;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;

    always #2.5 clk = ~clk;

    sdmmc_resp_checker dut (
        .clk(clk), .rst_n(rst_n), .sck_en(sck_en), .start(start),
        .long_mode(long_mode), .check_status(check_status), .cmd_in(cmd_in),
        .status_ref(status_ref), .status_mask(status_mask),
        .timeout_irq_en(timeout_irq_en), .error_irq_en(error_irq_en),
        .busy(busy), .done(done), .timeout_flag(timeout_flag),
        .resp_err_flag(resp_err_flag), .stop_dma(stop_dma),
        .irq_timeout(irq_timeout), .irq_error(irq_error),
        .card_status(card_status), .resp_token(resp_token)
    );

    always @(negedge clk) if (done) done_seen++;

    typedef struct packed {
        logic        chk;
        logic        corrupt;
        logic        endb;
        logic        ie;
        logic [5:0]  cmd;
        logic [31:0] status;
        logic [31:0] ref_v;
        logic [31:0] mask_v;
        logic        exp_err;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 1'b1, 6'h11, 32'h0000_0900, 32'h0,          32'h0,          1'b0},
        '{1'b0, 1'b1, 1'b1, 1'b1, 6'h11, 32'h0000_0900, 32'h0,          32'h0,          1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 6'h0D, 32'h0000_0B00, 32'h0,          32'h0,          1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 6'h0D, 32'h0000_0900, 32'h0000_0900, 32'hFFFF_FFFF, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 6'h0D, 32'h8000_0900, 32'h0000_0900, 32'hFFFF_FFFF, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 6'h07, 32'h8000_0900, 32'h0000_0900, 32'h7FFF_FFFF, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 6'h07, 32'hDEAD_BEEF, 32'h0,          32'hFFFF_FFFF, 1'b0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 6'h3A, 32'h1234_5678, 32'h0,          32'h0,          1'b1}
    };

    task automatic check(input logic [135:0] act, input logic [135:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7_of(input logic [39:0] bits);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = bits[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [47:0] mk_short(input logic [5:0] cmd, input logic [31:0] st,
                                             input logic corrupt, input logic endb);
        logic [39:0] hdr = {2'b00, cmd, st};
        logic [6:0]  c   = crc7_of(hdr) ^ {6'b0, corrupt};
        return {hdr, c, endb};
    endfunction

    // One sample: value held during the enable cycle, inverted otherwise (R11)
    task automatic tick_bit(input logic b);
        @(negedge clk); cmd_in = b;  sck_en = 1'b1;
        @(negedge clk); cmd_in = ~b; sck_en = 1'b0;
        @(negedge clk);
        @(negedge clk); cmd_in = 1'b1;
    endtask

    task automatic open_window(input logic lm, input logic chk);
        @(negedge clk); long_mode = lm; check_status = chk; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic send_bits(input logic [135:0] tok, input int len);
        for (int i = len - 1; i >= 0; i--) tick_bit(tok[i]);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0]  stok;
        logic [135:0] ltok;
        logic [127:0] pat;
        int           d0;

        repeat (3) @(negedge clk);
        check({133'b0, timeout_flag, resp_err_flag, done}, '0, "reset flags R1 R4 R10");
        check({134'b0, stop_dma, busy}, '0, "reset stop_dma R2");
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: short responses
        for (int v = 0; v < NV; v++) begin
            error_irq_en = VECS[v].ie;
            status_ref   = VECS[v].ref_v;
            status_mask  = VECS[v].mask_v;
            stok = mk_short(VECS[v].cmd, VECS[v].status, VECS[v].corrupt, VECS[v].endb);
            d0 = done_seen;
            open_window(1'b0, VECS[v].chk);
            send_bits({88'b0, stok}, 48);
            check(136'(resp_err_flag), 136'(VECS[v].exp_err), $sformatf("vec%0d err R4 R5 R6", v));
            check(136'(irq_error), 136'(VECS[v].exp_err & VECS[v].ie), $sformatf("vec%0d irq R7", v));
            check(136'(timeout_flag), '0, $sformatf("vec%0d no timeout R1", v));
            check(136'(card_status), 136'(VECS[v].status), $sformatf("vec%0d status R9", v));
            check(resp_token, {88'b0, stok}, $sformatf("vec%0d token R12 R11", v));
            check(136'(done_seen - d0), 136'(1), $sformatf("vec%0d done R10", v));
        end

        // R9: captured status clears at the next window
        open_window(1'b0, 1'b0);
        check(136'(card_status), '0, "status cleared R9");
        // R1: 63 idle samples then a valid token
        for (int i = 0; i < 63; i++) tick_bit(1'b1);
        check(136'(timeout_flag), '0, "63 idle no timeout R1");
        stok = mk_short(6'h02, 32'h0000_0500, 1'b0, 1'b1);
        send_bits({88'b0, stok}, 48);
        check({134'b0, timeout_flag, resp_err_flag}, '0, "late start accepted R1");

        // R1 R2 R3: timeout with interrupt disabled, then enabled
        timeout_irq_en = 1'b0;
        d0 = done_seen;
        open_window(1'b0, 1'b0);
        for (int i = 0; i < 64; i++) tick_bit(1'b1);
        check({133'b0, timeout_flag, stop_dma, resp_err_flag}, 136'b110, "timeout R1 R2");
        check(136'(irq_timeout), '0, "timeout irq gated R3");
        check(136'(done_seen - d0), 136'(1), "timeout done R10");
        timeout_irq_en = 1'b1;
        @(negedge clk);
        check(136'(irq_timeout), 136'(1), "timeout irq enabled R3");

        // R8: long token, bogus CRC field, status check requested but not applied
        pat  = {32'hA5C3_1E77, 32'h0F0F_1234, 32'hCAFE_F00D, 32'h1357_9BDF};
        ltok = {2'b00, 6'h3F, pat[126:0], 1'b1};
        status_mask = 32'hFFFF_FFFF;
        status_ref  = 32'h0;
        open_window(1'b1, 1'b1);
        check(136'(stop_dma), '0, "stop_dma cleared by start R2");
        send_bits(ltok, 136);
        check(136'(resp_err_flag), '0, "long no checks R8");
        check(resp_token, ltok, "long token R8 R12");
        ltok[0] = 1'b0;
        open_window(1'b1, 1'b0);
        send_bits(ltok, 136);
        check(136'(resp_err_flag), 136'(1), "long end bit R5 R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule